// File: doc/BRIEF.md
# Synchronous Serial Clock Edge Unit

This block supplies the bit timing for a serial port running in synchronous mode. It either generates the serial clock itself from a one-cycle bit-rate tick, or it accepts a serial clock from the far end. In both cases it turns that clock into single-cycle strobes on the system clock. One strobe tells the receive shift register when to sample the data line. The other tells the transmit shift register when to move to the next bit.

When the block generates the clock, the clock idles high and toggles on every bit-rate tick, so one bit lasts two ticks. It can run only while a character is being sent, or it can run all the time so that reception works with no transmission. When the clock comes from outside, it passes through a two-stage synchronizer before edge detection. A bypass setting removes that synchronizer, which permits a faster external clock but carries a risk of metastability.

The receive strobe fires on the rising serial-clock edge by default, or on the falling edge if selected. The transmit strobe always fires on the opposite edge, so outgoing data is stable at the moment the far end samples it.

Top module: `sync_clk_edge_unit`

## Requirements
- R1: After reset, `sclk_out` is 1, `sclk_oe` is 0, and both strobes are 0.
- R2: While `sync_en` is 0, both strobes are 0 and `sclk_oe` is 0. From the cycle after `sync_en` is sampled 0, `sclk_out` is 1.
- R3: In slave mode with `sync_bypass` = 0, a level change of `sclk_in` first sampled at clock edge k produces a one-cycle edge strobe in the cycle after edge k+1.
- R4: In slave mode with `sync_bypass` = 1, a level change of `sclk_in` first sampled at clock edge k produces a one-cycle edge strobe in the cycle after edge k.
- R5: With `fall_sample` = 0, `rx_strobe` marks rising serial-clock edges and `tx_strobe` marks falling edges. With `fall_sample` = 1, the two roles swap.
- R6: In master mode (`master_sel` = 1), `sclk_oe` is 1. The clock changes only at an edge where `bit_tick` is sampled 1, idles high, and produces its edge strobes in the cycle after each change.
- R7: In master mode with `free_run` = 0, the clock toggles on ticks only while `tx_active` is 1. After `tx_active` falls, a low clock returns high on the next tick and then stays high.
- R8: In master mode with `free_run` = 1, the clock toggles on every tick whatever the value of `tx_active`.
- R9: In slave mode, `free_run` and `tx_active` have no effect: `sclk_out` stays 1, `sclk_oe` stays 0, and the strobes follow `sclk_in` only.
- R10: `rx_strobe` and `tx_strobe` are never 1 in the same cycle, and neither stays 1 for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | Synchronous mode enable |
| master_sel | input | 1 | 1: generate the serial clock; 0: accept it from `sclk_in` |
| fall_sample | input | 1 | 1: receive samples on the falling edge |
| sync_bypass | input | 1 | 1: skip the input synchronizer in slave mode |
| free_run | input | 1 | 1: master clock runs continuously |
| bit_tick | input | 1 | One-cycle bit-rate tick (master mode) |
| tx_active | input | 1 | A character is being transmitted |
| sclk_in | input | 1 | External serial clock (slave mode) |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Output enable for the serial clock pin |
| rx_strobe | output | 1 | Receive sample strobe |
| tx_strobe | output | 1 | Transmit shift strobe |

## Verification
The checker tests on every cycle that the strobes are exclusive and one cycle wide. It also checks that a disabled unit parks the clock high, that the master clock never changes without a tick, and that a gated master clock stays high once it is idle. Other behaviours can only be shown by the bench's scenarios, which compare every cycle against a behavioural model. These include the exact strobe latency with and without the synchronizer, the swap of edge roles, gated versus free-running clock generation, and the fact that the master-only controls do nothing in slave mode.

// File: rtl/sce_pkg.sv
package sce_pkg;
  typedef enum logic {
    SRC_SLAVE  = 1'b0,
    SRC_MASTER = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_pair_t;
endpackage

// File: rtl/sce_sync_chain.sv
module sce_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic bypass,
  output logic cur,
  output logic prev
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] d_q;
  logic [LEN-1:0] d_d;

  always_comb begin
    d_d = {d_q[LEN-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= '1;
    else        d_q <= d_d;
  end

  always_comb begin
    if (bypass) begin
      cur  = d_q[0];
      prev = d_q[1];
    end else begin
      cur  = d_q[STAGES-1];
      prev = d_q[STAGES];
    end
  end
endmodule

// File: rtl/sce_master_clk.sv
module sce_master_clk (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic run,
  input  logic tick,
  output logic sclk,
  output logic sclk_prev
);
  logic sclk_q, sclk_d;
  logic prev_q;
  logic toggle_en;

  always_comb begin
    toggle_en = tick && (run || !sclk_q);
    if (!enable)        sclk_d = 1'b1;
    else if (toggle_en) sclk_d = !sclk_q;
    else                sclk_d = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      sclk_q <= sclk_d;
      prev_q <= sclk_q;
    end
  end

  assign sclk      = sclk_q;
  assign sclk_prev = prev_q;
endmodule

// File: rtl/sce_edge_route.sv
module sce_edge_route
  import sce_pkg::*;
(
  input  logic en,
  input  logic fall_sample,
  input  logic cur,
  input  logic prev,
  output logic rx_strobe,
  output logic tx_strobe
);
  edge_pair_t edges;

  always_comb begin
    edges.rise = en && cur && !prev;
    edges.fall = en && !cur && prev;
    if (fall_sample) begin
      rx_strobe = edges.fall;
      tx_strobe = edges.rise;
    end else begin
      rx_strobe = edges.rise;
      tx_strobe = edges.fall;
    end
  end
endmodule

// File: rtl/sync_clk_edge_unit.sv
module sync_clk_edge_unit
  import sce_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_en,
  input  logic master_sel,
  input  logic fall_sample,
  input  logic sync_bypass,
  input  logic free_run,
  input  logic bit_tick,
  input  logic tx_active,
  input  logic sclk_in,
  output logic sclk_out,
  output logic sclk_oe,
  output logic rx_strobe,
  output logic tx_strobe
);
  clk_src_e src;
  logic     mst_enable, mst_run;
  logic     s_cur, s_prev, m_cur, m_prev;
  logic     e_cur, e_prev;

  assign src        = master_sel ? SRC_MASTER : SRC_SLAVE;
  assign mst_enable = sync_en && (src == SRC_MASTER);
  assign mst_run    = mst_enable && (free_run || tx_active);

  sce_sync_chain #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (sclk_in),
    .bypass (sync_bypass),
    .cur    (s_cur),
    .prev   (s_prev)
  );

  sce_master_clk i_mclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (mst_enable),
    .run       (mst_run),
    .tick      (bit_tick),
    .sclk      (m_cur),
    .sclk_prev (m_prev)
  );

  always_comb begin
    if (src == SRC_MASTER) begin
      e_cur  = m_cur;
      e_prev = m_prev;
    end else begin
      e_cur  = s_cur;
      e_prev = s_prev;
    end
  end

  sce_edge_route i_route (
    .en          (sync_en),
    .fall_sample (fall_sample),
    .cur         (e_cur),
    .prev        (e_prev),
    .rx_strobe   (rx_strobe),
    .tx_strobe   (tx_strobe)
  );

  assign sclk_out = m_cur;
  assign sclk_oe  = mst_enable;
endmodule

// File: rtl/sce_checker.sv
module sce_checker (
  input logic clk,
  input logic rst_n,
  input logic sync_en,
  input logic master_sel,
  input logic free_run,
  input logic bit_tick,
  input logic tx_active,
  input logic sclk_out,
  input logic rx_strobe,
  input logic tx_strobe
);
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_strobe && tx_strobe));

  p_rx_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);

  p_tx_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |=> !tx_strobe);

  p_park_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> sclk_out);

  p_tick_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && master_sel && !bit_tick) |=> (!(sync_en && master_sel) || $stable(sclk_out)));

  p_gated_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && master_sel && !free_run && !tx_active && sclk_out) |=> sclk_out);
endmodule

bind sync_clk_edge_unit sce_checker i_sce_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_en    (sync_en),
  .master_sel (master_sel),
  .free_run   (free_run),
  .bit_tick   (bit_tick),
  .tx_active  (tx_active),
  .sclk_out   (sclk_out),
  .rx_strobe  (rx_strobe),
  .tx_strobe  (tx_strobe)
);

// File: tb/test_sync_clk_edge_unit.sv
module test_sync_clk_edge_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_en = 1'b0, master_sel = 1'b0, fall_sample = 1'b0;
  logic sync_bypass = 1'b0, free_run = 1'b0, bit_tick = 1'b0;
  logic tx_active = 1'b0, sclk_in = 1'b1;
  logic sclk_out, sclk_oe, rx_strobe, tx_strobe;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string tag = "R1";

  int tick_div = 3;
  int tick_cnt = 0;
  int half_per = 4;
  int half_cnt = 0;
  bit slave_run = 0;

  // behavioural reference state
  bit hist[$];
  bit mdl_sclk = 1;
  bit mdl_sprev = 1;

  always #(CLK_PERIOD/2) clk = !clk;

  sync_clk_edge_unit i_sync_clk_edge_unit (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .master_sel(master_sel),
    .fall_sample(fall_sample), .sync_bypass(sync_bypass), .free_run(free_run),
    .bit_tick(bit_tick), .tx_active(tx_active), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rx_strobe(rx_strobe), .tx_strobe(tx_strobe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {1'b1, 1'b1, 1'b1, 1'b1};
      mdl_sclk = 1;
      mdl_sprev = 1;
    end else begin
      bit on, going, nxt;
      hist.push_front(sclk_in);
      void'(hist.pop_back());
      on = sync_en && master_sel;
      going = on && (free_run || tx_active);
      if (!on) nxt = 1;
      else if (bit_tick && (going || !mdl_sclk)) nxt = !mdl_sclk;
      else nxt = mdl_sclk;
      mdl_sprev = mdl_sclk;
      mdl_sclk = nxt;
    end
  end

  task automatic chk(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit cur, prv, up, dn, erx, etx;
    if (master_sel) begin
      cur = mdl_sclk; prv = mdl_sprev;
    end else if (sync_bypass) begin
      cur = hist[0]; prv = hist[1];
    end else begin
      cur = hist[1]; prv = hist[2];
    end
    up = sync_en && cur && !prv;
    dn = sync_en && !cur && prv;
    erx = fall_sample ? dn : up;
    etx = fall_sample ? up : dn;
    chk(tag, "rx_strobe", rx_strobe, erx);
    chk(tag, "tx_strobe", tx_strobe, etx);
    chk(tag, "sclk_out", sclk_out, mdl_sclk);
    chk(tag, "sclk_oe", sclk_oe, sync_en && master_sel);
    chk("R10", "strobe exclusive", rx_strobe && tx_strobe, 1'b0);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      tick_cnt++;
      bit_tick = (tick_cnt % tick_div) == 0;
      if (slave_run) begin
        half_cnt++;
        if (half_cnt >= half_per) begin
          half_cnt = 0;
          sclk_in = !sclk_in;
        end
      end
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", "sclk_out", sclk_out, 1'b1);
    chk("R1", "sclk_oe", sclk_oe, 1'b0);
    chk("R1", "rx_strobe", rx_strobe, 1'b0);
    chk("R1", "tx_strobe", tx_strobe, 1'b0);
    rst_n = 1'b1;
    step(4);

    tag = "R2"; slave_run = 1; free_run = 1; tx_active = 1;
    step(40);
    master_sel = 1; step(30);
    master_sel = 0; free_run = 0; tx_active = 0;

    tag = "R3"; sync_en = 1; step(60);
    half_per = 1; step(20); half_per = 3; step(30);

    tag = "R4"; sync_bypass = 1; step(50);
    half_per = 1; step(20); half_per = 4;

    tag = "R5"; sync_bypass = 0; fall_sample = 1; step(50);
    sync_bypass = 1; step(30); sync_bypass = 0;

    tag = "R9"; free_run = 1; tx_active = 1; step(40);
    free_run = 0; step(20); tx_active = 0; step(20);

    tag = "R6"; slave_run = 0; fall_sample = 0; master_sel = 1; step(20);
    tag = "R7"; tx_active = 1; step(31); tx_active = 0; step(30);
    tx_active = 1; step(14); tx_active = 0; step(20);
    tag = "R8"; free_run = 1; step(50);
    tick_div = 1; step(20); tick_div = 5; step(40);
    tag = "R5"; fall_sample = 1; step(40);
    tag = "R2"; sync_en = 0; step(20); sync_en = 1; step(20);
    free_run = 0; step(30);

    finish_up();
  end
endmodule